// File: doc/BRIEF.md
# Fault Capture Recorder with Pre/Post-Trigger Windows

This block records four 8-bit current channels together with a small vector of trip-output bits. It writes one entry into a circular record slot on every sample strobe. When a trigger pulse is accepted, the block keeps the samples already taken before the trigger and fills in the same number after it. It then stamps the frozen window with the time on the timestamp bus at the trigger and opens the next slot for later events.

The bank holds the most recent `NREC` completed records. Once the bank is full, each new record replaces the oldest one. A host picks a record by age, where 0 is the newest, and gives a sample address within the window. It reads back the four channels, the trip bits and the stamp. Address 0 is always the oldest pre-trigger sample, whatever the circular write position was when the trigger came.

With the default parameters a window spans ten cycles of 16 samples each, five cycles before the trigger and five after. That gives 160 entries per record.

Top module: `fault_recorder`

## Requirements
- R1: Every cycle with `smp_stb` high stores `smp_ch` (channel 0 in bits [7:0], channel 3 in bits [31:24]) and `smp_trip` as one entry of the record being filled. The position advances circularly over `REC_N` = `SPC*(PRE_CYC+POST_CYC)` entries.
- R2: A trigger accepted in a cycle that also has a strobe makes that sample the first post-trigger sample. Without a strobe in that cycle, the next strobed sample is the first post-trigger sample.
- R3: A completed record holds the `PRE_N` = `SPC*PRE_CYC` samples before the trigger, then the `POST_N` = `SPC*POST_CYC` samples from it. Reading address a returns the a-th of these in time order, so address `PRE_N` is the first post-trigger sample.
- R4: `busy` goes high in the cycle after an accepted trigger. It goes low in the cycle after the strobe that stores the `POST_N`-th post-trigger sample, which completes the record.
- R5: A trigger arriving while `busy` is high has no effect. The stamp and the window of the record being filled stay as they were.
- R6: Each record returns on `rd_stamp` the `tstamp` value present in the cycle its trigger was accepted.
- R7: `rd_age` selects a record, with 0 the newest completed one. Up to `NREC` records are kept, and after more events the oldest are dropped. `rd_valid` is low for any age at or beyond the number of records kept.
- R8: `rd_valid`, `rd_data`, `rd_trip` and `rd_stamp` are registered. They reflect the `rd_age`/`rd_addr` present at the previous rising clock edge.
- R9: A read with `rd_addr` >= `REC_N` returns `rd_valid` low.
- R10: After reset `busy` is low and no record is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one entry stored per high cycle |
| smp_ch | input | NUM_CH*SAMP_W | Packed channel samples, channel 0 lowest |
| smp_trip | input | TRIP_W | Trip-output bits stored with each sample |
| trig | input | 1 | Trigger pulse |
| tstamp | input | TS_W | Current time, captured at an accepted trigger |
| busy | output | 1 | High while post-trigger samples are being filled |
| rd_age | input | AGE_W | Record select, 0 = newest |
| rd_addr | input | OFF_W | Sample index within the window, 0 = oldest |
| rd_valid | output | 1 | Read result refers to an existing record and in-range address |
| rd_data | output | NUM_CH*SAMP_W | Read channel samples |
| rd_trip | output | TRIP_W | Read trip bits |
| rd_stamp | output | TS_W | Timestamp of the selected record |

## Verification
Reads have a latency of one edge. The bench changes `rd_age` and `rd_addr` at a falling edge and samples every read output just after the next rising edge. `busy` changes at the edge that accepts the trigger and at the edge that takes the last post-trigger strobe. The bench checks it right after those edges, and again just before the final strobe to confirm it has not cleared early. A record becomes readable at the same edge that clears `busy`. The exhaustive readback of all kept records and addresses therefore starts only after that edge, and expected samples are recomputed from the global sample index.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Fill state of the active record slot
  typedef enum logic {
    ST_ARMED = 1'b0,  // rolling pre-trigger capture
    ST_POST  = 1'b1   // collecting post-trigger samples
  } fr_state_t;
endpackage

// File: rtl/fr_write_ctrl.sv
module fr_write_ctrl
  import fr_pkg::*;
#(
  parameter int REC_N  = 160,
  parameter int POST_N = 80,
  parameter int NSLOT  = 6,
  parameter int OFF_W  = 8,
  parameter int SLOT_W = 3,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic              trig,
  input  logic [TS_W-1:0]   tstamp,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [OFF_W-1:0]  wr_off,
  output logic              busy,
  output logic              commit,
  output logic [SLOT_W-1:0] commit_slot,
  output logic [OFF_W-1:0]  commit_tptr,
  output logic [TS_W-1:0]   commit_stamp
);
  localparam int PC_W = $clog2(POST_N + 1);

  fr_state_t         state;
  logic [OFF_W-1:0]  wptr;
  logic [OFF_W-1:0]  tptr_q;
  logic [SLOT_W-1:0] slot;
  logic [PC_W-1:0]   post_cnt;
  logic [TS_W-1:0]   stamp_q;
  logic              last_post;

  // Final post-trigger strobe closes the record
  always_comb begin
    last_post = (state == ST_POST) && smp_stb &&
                (post_cnt == PC_W'(POST_N - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ARMED;
      wptr     <= '0;
      tptr_q   <= '0;
      slot     <= '0;
      post_cnt <= '0;
      stamp_q  <= '0;
    end else begin
      if (smp_stb) begin
        wptr <= (wptr == OFF_W'(REC_N - 1)) ? '0 : wptr + 1'b1;
      end
      case (state)
        ST_ARMED: begin
          if (trig) begin
            state    <= ST_POST;
            tptr_q   <= wptr;
            stamp_q  <= tstamp;
            post_cnt <= smp_stb ? PC_W'(1) : '0;
          end
        end
        ST_POST: begin
          if (last_post) begin
            state    <= ST_ARMED;
            post_cnt <= '0;
            wptr     <= '0;
            slot     <= (slot == SLOT_W'(NSLOT - 1)) ? '0 : slot + 1'b1;
          end else if (smp_stb) begin
            post_cnt <= post_cnt + 1'b1;
          end
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  assign wr_en        = smp_stb;
  assign wr_slot      = slot;
  assign wr_off       = wptr;
  assign busy         = (state == ST_POST);
  assign commit       = last_post;
  assign commit_slot  = slot;
  assign commit_tptr  = tptr_q;
  assign commit_stamp = stamp_q;
endmodule

// File: rtl/fr_sample_ram.sv
module fr_sample_ram #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 960,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fr_record_table.sv
module fr_record_table #(
  parameter int NREC   = 5,
  parameter int NSLOT  = 6,
  parameter int REC_N  = 160,
  parameter int POST_N = 80,
  parameter int OFF_W  = 8,
  parameter int SLOT_W = 3,
  parameter int AGE_W  = 3,
  parameter int CNT_W  = 3,
  parameter int TS_W   = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [SLOT_W-1:0] commit_slot,
  input  logic [OFF_W-1:0]  commit_tptr,
  input  logic [TS_W-1:0]   commit_stamp,
  input  logic [AGE_W-1:0]  rd_age,
  input  logic [OFF_W-1:0]  rd_addr,
  output logic [AW-1:0]     ram_raddr,
  output logic              rd_valid,
  output logic [TS_W-1:0]   rd_stamp,
  output logic [CNT_W-1:0]  rec_cnt
);
  logic [TS_W-1:0]   stamp_tab [NSLOT];
  logic [OFF_W-1:0]  tptr_tab  [NSLOT];
  logic [SLOT_W-1:0] newest;
  logic [SLOT_W-1:0] phys;
  logic              age_ok;
  logic              addr_ok;
  int                phys_i;
  int                off_i;

  // Age -> physical slot, window index -> circular offset
  always_comb begin
    age_ok  = int'(rd_age) < NREC;
    addr_ok = int'(rd_addr) < REC_N;
    phys_i  = 0;
    if (age_ok) begin
      phys_i = int'(newest) + NSLOT - int'(rd_age);
      if (phys_i >= NSLOT) phys_i = phys_i - NSLOT;
    end
    phys  = SLOT_W'(phys_i);
    off_i = 0;
    if (addr_ok) begin
      // oldest pre-trigger entry sits POST_N past the trigger pointer
      off_i = int'(tptr_tab[phys]) + int'(rd_addr) + POST_N;
      if (off_i >= 2 * REC_N)  off_i = off_i - 2 * REC_N;
      else if (off_i >= REC_N) off_i = off_i - REC_N;
    end
    ram_raddr = AW'(phys_i * REC_N + off_i);
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      stamp_tab[commit_slot] <= commit_stamp;
      tptr_tab[commit_slot]  <= commit_tptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      newest   <= '0;
      rec_cnt  <= '0;
      rd_valid <= 1'b0;
      rd_stamp <= '0;
    end else begin
      if (commit) begin
        newest <= commit_slot;
        if (int'(rec_cnt) < NREC) rec_cnt <= rec_cnt + 1'b1;
      end
      rd_valid <= age_ok && addr_ok && (int'(rd_age) < int'(rec_cnt));
      rd_stamp <= stamp_tab[phys];
    end
  end
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder #(
  parameter int NUM_CH   = 4,
  parameter int SAMP_W   = 8,
  parameter int TRIP_W   = 4,
  parameter int SPC      = 16,
  parameter int PRE_CYC  = 5,
  parameter int POST_CYC = 5,
  parameter int NREC     = 5,
  parameter int TS_W     = 32,
  localparam int DW      = NUM_CH * SAMP_W,
  localparam int REC_N   = SPC * (PRE_CYC + POST_CYC),
  localparam int OFF_W   = (REC_N > 1) ? $clog2(REC_N) : 1,
  localparam int AGE_W   = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [DW-1:0]     smp_ch,
  input  logic [TRIP_W-1:0] smp_trip,
  input  logic              trig,
  input  logic [TS_W-1:0]   tstamp,
  output logic              busy,
  input  logic [AGE_W-1:0]  rd_age,
  input  logic [OFF_W-1:0]  rd_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [TRIP_W-1:0] rd_trip,
  output logic [TS_W-1:0]   rd_stamp
);
  localparam int POST_N = SPC * POST_CYC;
  localparam int NSLOT  = NREC + 1;  // one slot always filling
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CNT_W  = $clog2(NREC + 1);
  localparam int DEPTH  = NSLOT * REC_N;
  localparam int AW     = $clog2(DEPTH);
  localparam int WW     = DW + TRIP_W;

  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [OFF_W-1:0]  wr_off;
  logic [AW-1:0]     wr_addr;
  logic              commit;
  logic [SLOT_W-1:0] commit_slot;
  logic [OFF_W-1:0]  commit_tptr;
  logic [TS_W-1:0]   commit_stamp;
  logic [AW-1:0]     ram_raddr;
  logic [WW-1:0]     ram_q;
  logic [CNT_W-1:0]  rec_cnt;

  fr_write_ctrl #(
    .REC_N (REC_N), .POST_N(POST_N), .NSLOT(NSLOT),
    .OFF_W (OFF_W), .SLOT_W(SLOT_W), .TS_W (TS_W)
  ) u_wctl (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .trig(trig), .tstamp(tstamp),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_off(wr_off), .busy(busy),
    .commit(commit), .commit_slot(commit_slot),
    .commit_tptr(commit_tptr), .commit_stamp(commit_stamp)
  );

  assign wr_addr = AW'(int'(wr_slot) * REC_N + int'(wr_off));

  fr_sample_ram #(.WIDTH(WW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({smp_trip, smp_ch}),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  fr_record_table #(
    .NREC(NREC), .NSLOT(NSLOT), .REC_N(REC_N), .POST_N(POST_N),
    .OFF_W(OFF_W), .SLOT_W(SLOT_W), .AGE_W(AGE_W), .CNT_W(CNT_W),
    .TS_W(TS_W), .AW(AW)
  ) u_tab (
    .clk(clk), .rst(rst), .commit(commit), .commit_slot(commit_slot),
    .commit_tptr(commit_tptr), .commit_stamp(commit_stamp),
    .rd_age(rd_age), .rd_addr(rd_addr), .ram_raddr(ram_raddr),
    .rd_valid(rd_valid), .rd_stamp(rd_stamp), .rec_cnt(rec_cnt)
  );

  assign rd_data = ram_q[DW-1:0];
  assign rd_trip = ram_q[WW-1:DW];
endmodule

// File: rtl/fr_recorder_chk.sv
module fr_recorder_chk #(
  parameter int REC_N = 160,
  parameter int OFF_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             smp_stb,
  input logic             busy,
  input logic [OFF_W-1:0] rd_addr,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rec_cnt
);
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig));
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(smp_stb));
  // R7
  rec_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_cnt != $past(rec_cnt)) |-> $fell(busy));
  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (int'($past(rd_addr)) < REC_N));
  // R10
  valid_needs_rec_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rec_cnt != '0));
endmodule

bind fault_recorder fr_recorder_chk #(
  .REC_N(REC_N), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .smp_stb(smp_stb), .busy(busy),
  .rd_addr(rd_addr), .rd_valid(rd_valid), .rec_cnt(rec_cnt)
);

// File: tb/fault_recorder_test.sv
module fault_recorder_test;
  localparam int CLK_PERIOD = 10;
  localparam int SPC    = 4;
  localparam int PRE_N  = SPC * 5;
  localparam int POST_N = SPC * 5;
  localparam int REC_N  = PRE_N + POST_N;
  localparam int NREC   = 5;
  localparam int NEV    = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [31:0] smp_ch = '0;
  logic [3:0]  smp_trip = '0;
  logic        trig = 1'b0;
  logic [31:0] tstamp = '0;
  logic        busy;
  logic [2:0]  rd_age = '0;
  logic [5:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  rd_trip;
  logic [31:0] rd_stamp;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  int ev_n = 0;
  int exp_k  [NEV];
  int exp_ts [NEV];
  bit exp_gl [NEV];

  fault_recorder #(.SPC(SPC), .PRE_CYC(5), .POST_CYC(5), .NREC(NREC)) uut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_ch(smp_ch),
    .smp_trip(smp_trip), .trig(trig), .tstamp(tstamp), .busy(busy),
    .rd_age(rd_age), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_trip(rd_trip), .rd_stamp(rd_stamp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] chv(int idx);
    return {8'(idx * 7 + 1), 8'(idx + 64), 8'(idx * 3), 8'(idx)};
  endfunction

  function automatic logic [3:0] trv(int idx);
    return 4'(idx ^ (idx >> 3));
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int gap);
    @(negedge clk);
    smp_stb = 1'b1; smp_ch = chv(k); smp_trip = trv(k);
    @(negedge clk);
    smp_stb = 1'b0; k++;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input int age, input int addr);
    @(negedge clk);
    rd_age = 3'(age); rd_addr = 6'(addr);
    @(posedge clk); #1;
  endtask

  task automatic verify_all();
    int keep;
    keep = (ev_n < NREC) ? ev_n : NREC;
    for (int age = 0; age < keep; age++) begin
      int e;
      e = ev_n - 1 - age;
      for (int a = 0; a < REC_N; a++) begin
        int idx;
        idx = exp_k[e] - PRE_N + a;
        rd(age, a);
        chk(rd_valid === 1'b1, "R7/R8 valid", 64'(rd_valid), 1);
        chk(rd_data === chv(idx), (a < PRE_N) ? "R1/R3 pre data" : "R2/R3 post data",
            64'(rd_data), 64'(chv(idx)));
        chk(rd_trip === trv(idx), "R1 trip bits", 64'(rd_trip), 64'(trv(idx)));
        if (a == 0)
          chk(rd_stamp === 32'(exp_ts[e]), exp_gl[e] ? "R5 stamp kept" : "R6 stamp",
              64'(rd_stamp), 64'(exp_ts[e]));
      end
    end
    if (keep < NREC) begin
      rd(keep, 0);
      chk(rd_valid === 1'b0, "R7 missing record", 64'(rd_valid), 0);
    end
    rd(7, 0);
    chk(rd_valid === 1'b0, "R7 age beyond bank", 64'(rd_valid), 0);
    rd(0, REC_N);
    chk(rd_valid === 1'b0, "R9 addr limit", 64'(rd_valid), 0);
    rd(0, 63);
    chk(rd_valid === 1'b0, "R9 addr max", 64'(rd_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d cycles", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(busy === 1'b0, "R10 busy", 64'(busy), 0);
    rd(0, 0);
    chk(rd_valid === 1'b0, "R10 no record", 64'(rd_valid), 0);

    for (int i = 0; i < NEV; i++) begin
      int pre_len, gap, posted, ts;
      bit same, glitch;
      pre_len = PRE_N + 9 * i + 3;
      gap     = i % 3;
      same    = (i % 2) == 1;
      glitch  = (i == 2) || (i == 5);
      ts      = 32'h1000_0000 + i * 17;
      for (int s = 0; s < pre_len; s++) strobe(gap);
      // trigger
      @(negedge clk);
      trig = 1'b1; tstamp = 32'(ts);
      if (same) begin
        smp_stb = 1'b1; smp_ch = chv(k); smp_trip = trv(k);
      end
      exp_k[ev_n] = k; exp_ts[ev_n] = ts; exp_gl[ev_n] = glitch;
      @(posedge clk); #1;
      chk(busy === 1'b1, "R4 busy rise", 64'(busy), 1);
      @(negedge clk);
      trig = 1'b0; tstamp = 32'h5555_0000 + 32'(i);
      posted = 0;
      if (same) begin
        smp_stb = 1'b0; k++; posted = 1;
      end
      for (int p = posted; p < POST_N; p++) begin
        if (glitch && p == 5) begin
          @(negedge clk);
          trig = 1'b1; tstamp = 32'hDEAD_0000 + 32'(i);
          @(negedge clk);
          trig = 1'b0;
          chk(busy === 1'b1, "R5 busy held", 64'(busy), 1);
        end
        @(negedge clk);
        if (p == POST_N - 1) chk(busy === 1'b1, "R4 busy before last", 64'(busy), 1);
        smp_stb = 1'b1; smp_ch = chv(k); smp_trip = trv(k);
        @(posedge clk); #1;
        if (p == POST_N - 1) chk(busy === 1'b0, "R4 busy fall", 64'(busy), 0);
        @(negedge clk);
        smp_stb = 1'b0; k++;
        repeat (gap) @(negedge clk);
      end
      ev_n++;
      verify_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule